// File: doc/BRIEF.md
# Dynamic range enhancer gain controller

This block sits in one recording channel of an ADC and keeps the channel's net gain fixed while it moves gain between the analog preamplifier and the digital path. When the signal is quiet, it raises the preamplifier gain in 2 dB steps up to a programmable ceiling. On the same sample it applies a digital attenuation of the same size. The converter's own noise is then pushed down relative to the signal, and the recorded level does not change.

Each accepted sample is taken as the preamplifier output. The sample is attenuated by the current gain's multiplier, rounded and saturated, and then registered as the output. The magnitude of the attenuated sample feeds a peak-hold envelope that decays every few samples. The envelope, a hysteresis band and a fast headroom check decide the gain for the next sample.

A 4-bit code sets the trigger threshold and another 4-bit code sets the gain ceiling. A channel enable and a high-sample-rate flag can both force the block inactive.

Top module: `dre_gain_ctrl`

## Requirements
- R1: The threshold code c selects a trigger level of 2^(DATA_W-1) >> (c+2), which is -12 dB for c=0 and 6 dB lower for each increment. The gain steps up by one when the envelope is below this level and the gain is below the ceiling.
- R2: Threshold codes 10 to 15 behave exactly like code 7 (-54 dB).
- R3: `gain_o` counts 2 dB steps. Maximum-gain code m gives a ceiling of m+1 steps (2 dB for 0, 24 dB for 11, 30 dB for 14), and `gain_o` never rises above it.
- R4: Maximum-gain code 15 behaves exactly like code 11 (a ceiling of 12 steps).
- R5: After reset, `gain_o` is 0, `out_valid_o` is 0 and `out_sample_o` is 0.
- R6: While `chan_en_i` is low, `gain_o` is 0 from the next cycle on, and every sample passes to the output unchanged.
- R7: While `high_rate_i` is high, the block behaves as in R6.
- R8: One cycle after a sample is accepted, `out_valid_o` is high and `out_sample_o` equals sat(floor((x*A[g] + 2^14) / 2^15)). Here g is the `gain_o` value when the sample arrived and A[g] = round(32768 * 10^(-g/10)). `out_valid_o` is low one cycle after a cycle with no sample.
- R9: The envelope is max(E', |y|), where y is the attenuated sample. E' equals E - (E >> 3) on every 4th accepted sample after reset and equals E on the others.
- R10: The gain moves by at most one step per sample. It steps down when the envelope is at or above twice the trigger level, and it holds while the envelope lies between the trigger level and twice the trigger level.
- R11: An input sample with magnitude at or above 2^(DATA_W-2) sets `gain_o` to 0 after that sample.
- R12: If the ceiling falls below the current gain, `gain_o` is clamped to the new ceiling one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_valid_i | input | 1 | Sample strobe |
| sample_i | input | DATA_W | Signed preamplifier output sample |
| thr_code_i | input | 4 | Trigger threshold code |
| maxg_code_i | input | 4 | Gain ceiling code |
| chan_en_i | input | 1 | Channel enable |
| high_rate_i | input | 1 | Output rate above 192 kHz; forces the block inactive |
| gain_o | output | 4 | Added analog gain in 2 dB steps |
| out_valid_o | output | 1 | Output sample strobe |
| out_sample_o | output | DATA_W | Signed gain-compensated sample |

## Verification
For a sample accepted on one rising edge, the compensated sample, its strobe and the gain chosen for the next sample all appear after that same edge. The bench therefore reads all three on the following falling edge. A change to the enable, the rate flag or the ceiling acts on the first rising edge after it, and the bench checks `gain_o` one falling edge later. A reference model in the bench applies the preamplifier gain, the multiplier formula, the envelope and the step rules for every threshold code against several ceiling codes.

// File: rtl/dre_pkg.sv
package dre_pkg;
  localparam int unsigned GAIN_W = 4;
  localparam int unsigned CODE_W = 4;
  localparam int unsigned COEF_W = 16;
  localparam int unsigned COEF_FRAC = 15;

  // Q1.15 unsigned: round(32768 * 10^(-g/10))
  function automatic logic [COEF_W-1:0] att_coef(input logic [GAIN_W-1:0] g);
    case (g)
      4'd0:  return 16'd32768;
      4'd1:  return 16'd26029;
      4'd2:  return 16'd20675;
      4'd3:  return 16'd16423;
      4'd4:  return 16'd13045;
      4'd5:  return 16'd10362;
      4'd6:  return 16'd8231;
      4'd7:  return 16'd6538;
      4'd8:  return 16'd5193;
      4'd9:  return 16'd4125;
      4'd10: return 16'd3277;
      4'd11: return 16'd2603;
      4'd12: return 16'd2068;
      4'd13: return 16'd1642;
      4'd14: return 16'd1305;
      default: return 16'd1036;
    endcase
  endfunction

  function automatic logic [CODE_W-1:0] thr_fold(input logic [CODE_W-1:0] c);
    return (c > 4'd9) ? 4'd7 : c;
  endfunction

  function automatic logic [GAIN_W-1:0] ceil_of(input logic [CODE_W-1:0] c);
    return ((c == 4'hF) ? 4'd11 : c) + 4'd1;
  endfunction
endpackage

// File: rtl/dre_cfg_decode.sv
module dre_cfg_decode
  import dre_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic [CODE_W-1:0] thr_code_i,
  input  logic [CODE_W-1:0] maxg_code_i,
  output logic [DATA_W-1:0] thr_lvl_o,
  output logic [DATA_W-1:0] hyst_lvl_o,
  output logic [GAIN_W-1:0] ceil_o
);
  localparam logic [DATA_W-1:0] FULL = {1'b1, {(DATA_W-1){1'b0}}};

  logic [CODE_W:0] shamt;

  always_comb begin
    shamt      = {1'b0, thr_fold(thr_code_i)} + 5'd2;
    thr_lvl_o  = FULL >> shamt;
    hyst_lvl_o = thr_lvl_o << 1;
    ceil_o     = ceil_of(maxg_code_i);
  end
endmodule

// File: rtl/dre_atten.sv
module dre_atten
  import dre_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic signed [DATA_W-1:0] x_i,
  input  logic [GAIN_W-1:0]        gain_i,
  output logic [DATA_W-1:0]        mag_o,
  output logic                     y_valid_o,
  output logic signed [DATA_W-1:0] y_o
);
  localparam int unsigned PW = DATA_W + COEF_W + 1;
  localparam logic signed [PW-1:0] HALF = PW'(1) <<< (COEF_FRAC - 1);
  localparam logic signed [PW-1:0] YMAX = (PW'(1) <<< (DATA_W - 1)) - PW'(1);
  localparam logic signed [PW-1:0] YMIN = -(PW'(1) <<< (DATA_W - 1));

  logic [COEF_W-1:0]        coef;
  logic signed [PW-1:0]     prod, rnd, shf;
  logic signed [DATA_W-1:0] y_c;
  logic [DATA_W-1:0]        y_u;

  always_comb begin
    coef = att_coef(gain_i);
    prod = PW'(x_i) * PW'(signed'({1'b0, coef}));
    rnd  = prod + HALF;
    shf  = rnd >>> COEF_FRAC;
    if (shf > YMAX)      y_c = YMAX[DATA_W-1:0];
    else if (shf < YMIN) y_c = YMIN[DATA_W-1:0];
    else                 y_c = shf[DATA_W-1:0];
    y_u   = y_c;
    mag_o = y_u[DATA_W-1] ? (~y_u + DATA_W'(1)) : y_u;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y_valid_o <= 1'b0;
      y_o       <= '0;
    end else begin
      y_valid_o <= valid_i;
      if (valid_i) y_o <= y_c;
    end
  end

  a_r8_strobe_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> y_valid_o);
  a_r8_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !y_valid_o);
endmodule

// File: rtl/dre_envelope.sv
module dre_envelope #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned DECAY_N  = 4,
  parameter int unsigned DECAY_SH = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] mag_i,
  output logic [DATA_W-1:0] env_next_o
);
  logic [DATA_W-1:0] env_q, decayed;
  logic              decay_now;

  generate
    if (DECAY_N > 1) begin : g_cnt
      localparam int unsigned CW = $clog2(DECAY_N);
      logic [CW-1:0] cnt_q;
      assign decay_now = (cnt_q == CW'(DECAY_N - 1));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      cnt_q <= '0;
        else if (valid_i) cnt_q <= decay_now ? '0 : cnt_q + CW'(1);
      end
    end else begin : g_every
      assign decay_now = 1'b1;
    end
  endgenerate

  always_comb begin
    decayed    = decay_now ? (env_q - (env_q >> DECAY_SH)) : env_q;
    env_next_o = (mag_i > decayed) ? mag_i : decayed;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      env_q <= '0;
    else if (valid_i) env_q <= env_next_o;
  end

  a_r9_peak_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> env_q >= $past(mag_i));
  a_r9_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(env_q));
endmodule

// File: rtl/dre_gain_step.sv
module dre_gain_step
  import dre_pkg::*;
#(
  parameter int unsigned LVL_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              valid_i,
  input  logic              hot_i,
  input  logic [LVL_W-1:0]  env_i,
  input  logic [LVL_W-1:0]  thr_i,
  input  logic [LVL_W-1:0]  hyst_i,
  input  logic [GAIN_W-1:0] ceil_i,
  output logic [GAIN_W-1:0] gain_o
);
  localparam logic [GAIN_W-1:0] ONE = GAIN_W'(1);

  logic [GAIN_W-1:0] gain_q, gain_d;

  always_comb begin
    gain_d = gain_q;
    if (!active_i) begin
      gain_d = '0;
    end else if (valid_i) begin
      if (hot_i)                gain_d = '0;
      else if (gain_q > ceil_i) gain_d = ceil_i;
      else if (env_i >= hyst_i) begin
        if (gain_q != '0) gain_d = gain_q - ONE;
      end else if (env_i < thr_i && gain_q < ceil_i) gain_d = gain_q + ONE;
    end else if (gain_q > ceil_i) begin
      gain_d = ceil_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gain_q <= '0;
    else         gain_q <= gain_d;
  end

  assign gain_o = gain_q;

  a_r6_inactive_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> gain_q == '0);
  a_r11_hot_cut: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && active_i && hot_i) |=> gain_q == '0);
  a_r12_clamp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && gain_q > ceil_i) |=> gain_q <= $past(ceil_i));
  a_r10_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && active_i && !hot_i && gain_q <= ceil_i) |=>
      ({1'b0, gain_q} <= {1'b0, $past(gain_q)} + 5'd1) &&
      ({1'b0, gain_q} + 5'd1 >= {1'b0, $past(gain_q)}));
endmodule

// File: rtl/dre_gain_ctrl.sv
module dre_gain_ctrl
  import dre_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned DECAY_N  = 4,
  parameter int unsigned DECAY_SH = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     sample_valid_i,
  input  logic signed [DATA_W-1:0] sample_i,
  input  logic [3:0]               thr_code_i,
  input  logic [3:0]               maxg_code_i,
  input  logic                     chan_en_i,
  input  logic                     high_rate_i,
  output logic [3:0]               gain_o,
  output logic                     out_valid_o,
  output logic signed [DATA_W-1:0] out_sample_o
);
  localparam logic [DATA_W-1:0] HOT_LVL = {2'b01, {(DATA_W-2){1'b0}}};

  logic [DATA_W-1:0] thr_lvl, hyst_lvl, y_mag, env_next, x_u, x_mag;
  logic [GAIN_W-1:0] ceil_steps;
  logic              active, hot;

  always_comb begin
    active = chan_en_i & ~high_rate_i;
    x_u    = sample_i;
    x_mag  = x_u[DATA_W-1] ? (~x_u + DATA_W'(1)) : x_u;
    hot    = (x_mag >= HOT_LVL);
  end

  dre_cfg_decode #(.DATA_W(DATA_W)) u_decode (
    .thr_code_i (thr_code_i),
    .maxg_code_i(maxg_code_i),
    .thr_lvl_o  (thr_lvl),
    .hyst_lvl_o (hyst_lvl),
    .ceil_o     (ceil_steps)
  );

  dre_atten #(.DATA_W(DATA_W)) u_atten (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (sample_valid_i),
    .x_i      (sample_i),
    .gain_i   (gain_o),
    .mag_o    (y_mag),
    .y_valid_o(out_valid_o),
    .y_o      (out_sample_o)
  );

  dre_envelope #(.DATA_W(DATA_W), .DECAY_N(DECAY_N), .DECAY_SH(DECAY_SH)) u_env (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (sample_valid_i),
    .mag_i     (y_mag),
    .env_next_o(env_next)
  );

  dre_gain_step #(.LVL_W(DATA_W)) u_step (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .active_i(active),
    .valid_i (sample_valid_i),
    .hot_i   (hot),
    .env_i   (env_next),
    .thr_i   (thr_lvl),
    .hyst_i  (hyst_lvl),
    .ceil_i  (ceil_steps),
    .gain_o  (gain_o)
  );

  a_r3_gain_ceiling: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(maxg_code_i) && $past(gain_o) <= ceil_steps |-> gain_o <= ceil_steps);
  a_r7_high_rate_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    high_rate_i |=> gain_o == 4'd0);
endmodule

// File: tb/dre_gain_ctrl_tb.sv
`timescale 1ns/1ps
module dre_gain_ctrl_tb;
  localparam int DATA_W = 16;
  localparam int DECAY_N = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sample_valid_i = 1'b0;
  logic signed [DATA_W-1:0] sample_i = '0;
  logic [3:0] thr_code_i = 4'd7;
  logic [3:0] maxg_code_i = 4'd11;
  logic chan_en_i = 1'b1;
  logic high_rate_i = 1'b0;
  logic [3:0] gain_o;
  logic out_valid_o;
  logic signed [DATA_W-1:0] out_sample_o;

  int total = 0;
  int bad = 0;
  bit done = 0;
  int m_g, m_env, m_cnt, m_thr, m_mg;
  bit m_en, m_hi;

  always #10 clk = ~clk;

  dre_gain_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .sample_valid_i(sample_valid_i), .sample_i(sample_i),
    .thr_code_i(thr_code_i), .maxg_code_i(maxg_code_i), .chan_en_i(chan_en_i),
    .high_rate_i(high_rate_i), .gain_o(gain_o), .out_valid_o(out_valid_o),
    .out_sample_o(out_sample_o)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int sat16(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  function automatic int coef(input int g);
    return $rtoi(32768.0 * (10.0 ** (-g / 10.0)) + 0.5);
  endfunction

  function automatic int preamp(input int a, input int g);
    real r;
    r = a * (10.0 ** (g / 10.0));
    if (r >= 32767.0) return 32767;
    if (r <= -32768.0) return -32768;
    return (r < 0.0) ? $rtoi(r - 0.5) : $rtoi(r + 0.5);
  endfunction

  function automatic int trig_lvl();
    int c;
    c = (m_thr > 9) ? 7 : m_thr;
    return 32768 >> (c + 2);
  endfunction

  function automatic int ceil_steps();
    return ((m_mg == 15) ? 11 : m_mg) + 1;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    sample_valid_i = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    m_g = 0; m_env = 0; m_cnt = 0;
    @(negedge clk);
  endtask

  // called at a falling edge
  task automatic set_cfg(input int thr, input int mg, input bit en, input bit hi,
                         input string req);
    m_thr = thr; m_mg = mg; m_en = en; m_hi = hi;
    thr_code_i = 4'(thr); maxg_code_i = 4'(mg); chan_en_i = en; high_rate_i = hi;
    if (!en || hi) m_g = 0;
    else if (m_g > ceil_steps()) m_g = ceil_steps();
    @(posedge clk); @(negedge clk);
    check(req, "gain after config", int'(gain_o), m_g);
  endtask

  task automatic send(input int a, input string req);
    int x, y, mag, dec, envn, t, gn, cl;
    longint p;
    x = preamp(a, m_g);
    p = longint'(x) * longint'(coef(m_g)) + 64'sd16384;
    y = sat16(p >>> 15);
    mag = (y < 0) ? -y : y;
    dec = (m_cnt == DECAY_N - 1) ? (m_env - (m_env >> 3)) : m_env;
    m_cnt = (m_cnt + 1) % DECAY_N;
    envn = (mag > dec) ? mag : dec;
    m_env = envn;
    t = trig_lvl();
    cl = ceil_steps();
    gn = m_g;
    if (!m_en || m_hi) gn = 0;
    else if (x >= 16384 || x <= -16384) gn = 0;
    else if (m_g > cl) gn = cl;
    else if (envn >= 2 * t) begin if (m_g > 0) gn = m_g - 1; end
    else if (envn < t && m_g < cl) gn = m_g + 1;
    sample_i = DATA_W'(x);
    sample_valid_i = 1'b1;
    @(posedge clk); @(negedge clk);
    sample_valid_i = 1'b0;
    check("R8", "out_valid", int'(out_valid_o), 1);
    check("R8", "out_sample", int'(out_sample_o), y);
    check(req, "gain", int'(gain_o), gn);
    check("R3", "gain within ceiling", (int'(gain_o) <= cl) ? 1 : 0, 1);
    m_g = gn;
    @(posedge clk); @(negedge clk);
    check("R8", "strobe idle", int'(out_valid_o), 0);
  endtask

  initial begin
    int mgs[5] = '{0, 3, 11, 14, 15};
    string tg;
    int t;
    do_reset();
    check("R5", "reset gain", int'(gain_o), 0);
    check("R5", "reset valid", int'(out_valid_o), 0);
    check("R5", "reset sample", int'(out_sample_o), 0);

    for (int thr = 0; thr < 16; thr++) begin
      for (int k = 0; k < 5; k++) begin
        do_reset();
        set_cfg(thr, mgs[k], 1'b1, 1'b0, "R1");
        tg = (thr > 9) ? "R2" : (mgs[k] == 15) ? "R4" : "R1";
        t = trig_lvl();
        for (int i = 0; i < 20; i++) send((i % 5) - 2, tg);
        for (int i = 0; i < 8; i++) send((i % 2 == 0) ? (t + t / 2) : -(t + t / 2), "R10");
        for (int i = 0; i < 6; i++) send(3 * t, "R10");
        for (int i = 0; i < 40; i++) send(0, "R9");
        send(20000, "R11");
      end
    end

    do_reset();
    set_cfg(7, 14, 1'b1, 1'b0, "R3");
    for (int i = 0; i < 20; i++) send(1, "R3");
    check("R3", "gain reached ceiling", int'(gain_o), 15);
    set_cfg(7, 2, 1'b1, 1'b0, "R12");
    check("R12", "clamped gain", int'(gain_o), 3);
    send(1, "R12");

    set_cfg(7, 11, 1'b0, 1'b0, "R6");
    send(1234, "R6");
    check("R6", "passthrough", int'(out_sample_o), 1234);
    send(-32768, "R6");
    check("R6", "passthrough negative", int'(out_sample_o), -32768);

    set_cfg(7, 11, 1'b1, 1'b0, "R1");
    for (int i = 0; i < 10; i++) send(2, "R1");
    set_cfg(7, 11, 1'b1, 1'b1, "R7");
    send(-777, "R7");
    check("R7", "passthrough", int'(out_sample_o), -777);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule